// File: doc/BRIEF.md
# Dual-Bank Address Generation Unit

This unit supplies the two memory addresses needed by a dual-memory parallel move in a single cycle: one address for the X memory and one for the Y memory. It keeps a file of eight 16-bit pointer registers, each paired with a 16-bit offset register of the same index. Pointers 0 to 3 form the lower bank and pointers 4 to 7 the upper bank. A move has to take one address from each bank.

For each move, the caller names a pointer index and an addressing mode for each memory. The unit presents the pointer's current value as the effective address in the same cycle. It then writes the post-updated pointer back at the next clock edge. The update can leave the pointer unchanged, step it by one in either direction, or add its paired offset.

If both addresses come from the same bank, the unit raises a flag and blocks every pointer update for that move. A separate load port writes pointers or offsets, and a read port shows any pair of registers.

Top module: `dual_bank_agu`

## Requirements
- R1: After reset, every pointer and every offset register reads as zero on the read port.
- R2: With `ld_en` high at a clock edge, `ld_data` is written to the pointer (`ld_ofs`=0) or to the offset (`ld_ofs`=1) at index `ld_idx`. The read port `rd_ptr`/`rd_ofs` at index `rd_idx` shows the new value from the following cycle on.
- R3: `x_addr` and `y_addr` equal the current value of the pointer named by `x_idx` and `y_idx`, in the same cycle and before any update. The update applies only from the next cycle.
- R4: Mode encodings are as follows. `2'b00` leaves the pointer unchanged. `2'b01` adds one. `2'b10` subtracts one. `2'b11` adds the offset register of the same index. For example, pointer 4 = 0x0100 with offset 4 = 0x0023 issues 0x0100 and becomes 0x0123, and pointer 0 = 0x1000 in mode `2'b01` issues 0x1000 and becomes 0x1001.
- R5: Moves never change an offset register. Only the load port writes it.
- R6: The bank of an index is its top bit, so indices 0-3 are lower and 4-7 are upper. While `mv_en` is high, `illegal` is high in the same cycle exactly when `x_idx` and `y_idx` lie in the same bank. `illegal` is low whenever `mv_en` is low.
- R7: When `illegal` is high, neither pointer is updated at the clock edge.
- R8: A legal move (`mv_en` high, `illegal` low) writes both updated pointers together at the same clock edge. With `mv_en` low, no pointer changes.
- R9: If a pointer load and a move update target the same pointer at the same edge, the loaded value is kept.
- R10: Pointer arithmetic wraps modulo 2^16. For example, 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mv_en | input | 1 | A dual move is requested this cycle |
| x_idx | input | 3 | Pointer index for the X address |
| x_mode | input | 2 | Addressing mode for the X pointer |
| y_idx | input | 3 | Pointer index for the Y address |
| y_mode | input | 2 | Addressing mode for the Y pointer |
| ld_en | input | 1 | Load strobe |
| ld_ofs | input | 1 | Load target: 0 pointer, 1 offset |
| ld_idx | input | 3 | Load index |
| ld_data | input | 16 | Load value |
| rd_idx | input | 3 | Read index |
| rd_ptr | output | 16 | Pointer at `rd_idx` |
| rd_ofs | output | 16 | Offset at `rd_idx` |
| x_addr | output | 16 | Effective X address |
| y_addr | output | 16 | Effective Y address |
| illegal | output | 1 | Same-bank combination flag |

## Verification
The main sweep tries every pair of X and Y indices with every pair of modes. That covers 1024 moves on registers preloaded with values near the wrap points. The same-bank pairs show that the flag blocks both writes. The cross-bank pairs tell the four update rules apart, including wrap in both directions.

Directed moves repeat the two worked examples, a collision between a load and an update, and idle cycles with `mv_en` low. A final read of every offset shows that 1024 moves left all of them untouched.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      AM_HOLD = 2'b00,
      AM_INC  = 2'b01,
      AM_DEC  = 2'b10,
      AM_OFS  = 2'b11
   } amode_e;
endpackage

// File: rtl/agu_next.sv
module agu_next
   import agu_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] ofs,
   input  logic [1:0]    mode,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] ONE = AW'(1);

   amode_e m;
   assign m = amode_e'(mode);

   always_comb begin
      unique case (m)
         AM_INC:  nxt = cur + ONE;
         AM_DEC:  nxt = cur - ONE;
         AM_OFS:  nxt = cur + ofs;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
   parameter int AW   = 16,
   parameter int NREG = 8,
   localparam int IW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_en,
   input  logic                      ld_ofs,
   input  logic [IW-1:0]             ld_idx,
   input  logic [AW-1:0]             ld_data,
   input  logic                      wa_en,
   input  logic [IW-1:0]             wa_idx,
   input  logic [AW-1:0]             wa_val,
   input  logic                      wb_en,
   input  logic [IW-1:0]             wb_idx,
   input  logic [AW-1:0]             wb_val,
   output logic [NREG-1:0][AW-1:0]   ptr_q,
   output logic [NREG-1:0][AW-1:0]   ofs_q
);
   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic ld_ptr_hit, ld_ofs_hit, wa_hit, wb_hit;
      assign ld_ptr_hit = ld_en && !ld_ofs && (ld_idx == IW'(k));
      assign ld_ofs_hit = ld_en &&  ld_ofs && (ld_idx == IW'(k));
      assign wa_hit     = wa_en && (wa_idx == IW'(k));
      assign wb_hit     = wb_en && (wb_idx == IW'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q[k] <= '0;
            ofs_q[k] <= '0;
         end else begin
            if (ld_ptr_hit)  ptr_q[k] <= ld_data;
            else if (wa_hit) ptr_q[k] <= wa_val;
            else if (wb_hit) ptr_q[k] <= wb_val;
            if (ld_ofs_hit)  ofs_q[k] <= ld_data;
         end
      end
   end

   AST_OFS_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && ld_ofs) |=> $stable(ofs_q)); // R5

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wa_en && !wb_en && !ld_en) |=> $stable(ptr_q)); // R7

   AST_WRITES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && wb_en) |-> (wa_idx != wb_idx)); // R6

   AST_COMMIT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && !(ld_en && !ld_ofs && ld_idx == wa_idx))
      |=> ptr_q[$past(wa_idx)] == $past(wa_val)); // R8
endmodule

// File: rtl/dual_bank_agu.sv
module dual_bank_agu
   import agu_pkg::*;
#(
   parameter int AW   = 16,
   parameter int NREG = 8,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mv_en,
   input  logic [IW-1:0] x_idx,
   input  logic [1:0]    x_mode,
   input  logic [IW-1:0] y_idx,
   input  logic [1:0]    y_mode,
   input  logic          ld_en,
   input  logic          ld_ofs,
   input  logic [IW-1:0] ld_idx,
   input  logic [AW-1:0] ld_data,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] rd_ofs,
   output logic [AW-1:0] x_addr,
   output logic [AW-1:0] y_addr,
   output logic          illegal
);
   initial begin
      if (AW < 2) $error("AW must be at least 2");
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) $error("NREG must be a power of two >= 2");
   end

   logic [NREG-1:0][AW-1:0] ptr_q, ofs_q;
   logic [1:0][IW-1:0]      sel_idx;
   logic [1:0][1:0]         sel_mode;
   logic [1:0][AW-1:0]      cur_v, nxt_v;
   logic                    upd;

   assign sel_idx  = {y_idx, x_idx};
   assign sel_mode = {y_mode, x_mode};

   for (genvar p = 0; p < 2; p++) begin : g_port
      assign cur_v[p] = ptr_q[sel_idx[p]];
      agu_next #(.AW(AW)) u_next (
         .cur  (cur_v[p]),
         .ofs  (ofs_q[sel_idx[p]]),
         .mode (sel_mode[p]),
         .nxt  (nxt_v[p])
      );
   end

   assign illegal = mv_en && (x_idx[IW-1] == y_idx[IW-1]);
   assign upd     = mv_en && !illegal;
   assign x_addr  = cur_v[0];
   assign y_addr  = cur_v[1];
   assign rd_ptr  = ptr_q[rd_idx];
   assign rd_ofs  = ofs_q[rd_idx];

   agu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_ofs  (ld_ofs),
      .ld_idx  (ld_idx),
      .ld_data (ld_data),
      .wa_en   (upd),
      .wa_idx  (x_idx),
      .wa_val  (nxt_v[0]),
      .wb_en   (upd),
      .wb_idx  (y_idx),
      .wb_val  (nxt_v[1]),
      .ptr_q   (ptr_q),
      .ofs_q   (ofs_q)
   );

   AST_ILLEGAL_ONLY_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> mv_en); // R6

   AST_X_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_en && !illegal && !ld_en && x_mode == 2'b01) ##1 (x_idx == $past(x_idx))
      |-> x_addr == $past(x_addr) + AW'(1)); // R4
endmodule

// File: tb/tb_dual_bank_agu.sv
module tb_dual_bank_agu;
   localparam int CLK_P = 10;
   localparam int AW = 16;
   localparam int NREG = 8;

   logic clk = 0, rst_n = 0;
   logic mv_en = 0, ld_en = 0, ld_ofs = 0;
   logic [2:0] x_idx = 0, y_idx = 0, ld_idx = 0, rd_idx = 0;
   logic [1:0] x_mode = 0, y_mode = 0;
   logic [15:0] ld_data = 0;
   logic [15:0] rd_ptr, rd_ofs, x_addr, y_addr;
   logic illegal;

   logic [15:0] rm [NREG];
   logic [15:0] nm [NREG];
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_bank_agu #(.AW(AW), .NREG(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .mv_en(mv_en), .x_idx(x_idx), .x_mode(x_mode),
      .y_idx(y_idx), .y_mode(y_mode), .ld_en(ld_en), .ld_ofs(ld_ofs),
      .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_ptr(rd_ptr),
      .rd_ofs(rd_ofs), .x_addr(x_addr), .y_addr(y_addr), .illegal(illegal));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] step(logic [15:0] c, logic [15:0] o, logic [1:0] m);
      case (m)
         2'd1: return c + 16'd1;
         2'd2: return c - 16'd1;
         2'd3: return c + o;
         default: return c;
      endcase
   endfunction

   task automatic load(bit ofs, int idx, logic [15:0] d);
      @(negedge clk);
      ld_en = 1; ld_ofs = ofs; ld_idx = 3'(idx); ld_data = d;
      @(posedge clk);
      if (ofs) nm[idx] = d; else rm[idx] = d;
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic read_chk(string req, int idx);
      @(negedge clk);
      rd_idx = 3'(idx);
      #1;
      check(req, rd_ptr, rm[idx]);
      check(req, rd_ofs, nm[idx]);
   endtask

   task automatic move(int xi, int xm, int yi, int ym);
      bit same;
      logic [15:0] nx, ny;
      @(negedge clk);
      mv_en = 1; x_idx = 3'(xi); y_idx = 3'(yi); x_mode = 2'(xm); y_mode = 2'(ym);
      #1;
      same = ((xi >> 2) == (yi >> 2));
      check("R3 x_addr", x_addr, rm[xi]);
      check("R3 y_addr", y_addr, rm[yi]);
      check("R6 illegal", illegal, same);
      nx = step(rm[xi], nm[xi], 2'(xm));
      ny = step(rm[yi], nm[yi], 2'(ym));
      @(posedge clk);
      if (!same) begin rm[xi] = nx; rm[yi] = ny; end  // R7 / R8
      @(negedge clk);
      mv_en = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NREG; k++) begin rm[k] = 0; nm[k] = 0; end
      #(CLK_P * 2 + 2);
      rst_n = 1;
      // R1 reset state
      for (int k = 0; k < NREG; k++) read_chk("R1 reset", k);

      // R2 loads, values near wrap points
      for (int k = 0; k < NREG; k++) begin
         load(0, k, 16'hFFFE + 16'(k * 16'h2345));
         load(1, k, 16'h0023 + 16'(k * 16'h1111));
      end
      for (int k = 0; k < NREG; k++) read_chk("R2 load", k);

      // R4 worked examples
      load(0, 4, 16'h0100); load(1, 4, 16'h0023); load(0, 0, 16'h1000);
      move(0, 1, 4, 3);
      read_chk("R4 inc", 0);
      check("R4 inc value", rm[0], 16'h1001);
      read_chk("R4 ofs", 4);
      check("R4 ofs value", rm[4], 16'h0123);

      // R10 wrap both directions
      load(0, 1, 16'hFFFF); load(0, 5, 16'h0000);
      move(1, 1, 5, 2);
      read_chk("R10 wrap up", 1);
      check("R10 wrap up value", rm[1], 16'h0000);
      read_chk("R10 wrap down", 5);
      check("R10 wrap down value", rm[5], 16'hFFFF);

      // R7 same-bank move suppresses both updates
      move(2, 1, 3, 2);
      read_chk("R7 x kept", 2);
      read_chk("R7 y kept", 3);

      // R8 no move -> nothing changes
      @(negedge clk); mv_en = 0; x_mode = 2'd1; y_mode = 2'd1;
      @(posedge clk);
      for (int k = 0; k < NREG; k++) read_chk("R8 idle", k);

      // R9 load vs update collision: load wins
      @(negedge clk);
      mv_en = 1; x_idx = 3'd6; x_mode = 2'd1; y_idx = 3'd2; y_mode = 2'd1;
      ld_en = 1; ld_ofs = 0; ld_idx = 3'd6; ld_data = 16'hBEEF;
      @(posedge clk);
      rm[6] = 16'hBEEF; rm[2] = rm[2] + 16'd1;
      @(negedge clk); mv_en = 0; ld_en = 0;
      read_chk("R9 collision", 6);
      read_chk("R9 other port", 2);

      // Exhaustive sweep: all index pairs x all mode pairs (R3 R4 R6 R7 R8 R10)
      for (int xi = 0; xi < NREG; xi++)
         for (int yi = 0; yi < NREG; yi++)
            for (int xm = 0; xm < 4; xm++)
               for (int ym = 0; ym < 4; ym++) begin
                  move(xi, xm, yi, ym);
                  read_chk("R4 sweep", xi);
               end

      // R5 offsets untouched after all moves
      for (int k = 0; k < NREG; k++) read_chk("R5 offsets", k);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule